// File: doc/BRIEF.md
# Flash Command Decoder with Protection Checks

This block is the command front end of a behavioural NOR-style flash model. Every accepted bus write carries a command byte in its low eight data bits. The block follows the two-cycle sequences for word program and full-chip erase, and decides what the read port returns: array data, or the status register. The array data comes from a separate array model.

Before it starts an operation, the block runs the protection checks. A digital `vpp_ok` input stands in for the programming-supply lockout. The boot blocks are guarded by the write-protect input, and every block has its own lock bit. If the checks pass, the block sends a one-cycle request to a separate sequencer, together with the captured address and data, or with the mask of blocks to erase. If a check fails, or a sequence is malformed, the block sets sticky error bits in the status register. A ready/busy output reflects the sequencer's busy signal.

The address splits into blocks by its upper `BLK_BITS` bits. Blocks numbered below `BOOT_BLKS` are boot blocks.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the read port returns `arr_rdata`, `ry_by` is 1, `seq_req` is 0 and all status error bits are clear, so a later 70h gives status 0080h.
- R2: A setup byte of 40h or 10h followed by a second write to an unlocked block, with `vpp_ok` high, pulses `seq_req` for exactly one cycle. That pulse comes in the cycle after the second write, with `seq_op`=0 and with `seq_addr`/`seq_data` equal to that write's address and data.
- R3: After a program or erase setup byte, reads return the status word until FFh is written. FFh selects array reads and 70h selects status reads.
- R4: The status word has zeros in its upper byte and zeros in bits 6, 2 and 0. Bit 7 is the inverse of `seq_busy`, and `ry_by` equals the inverse of `seq_busy`.
- R5: A program second cycle with `vpp_ok` low issues no request and sets status bits 3 and 4.
- R6: A block counts as locked when its `lock_bits` bit is 1, or when it is a boot block and `wp_n` is 0. A program second cycle to a locked block issues no request and sets bits 1 and 4. Non-boot blocks ignore `wp_n`.
- R7: 30h followed by D0h, with `vpp_ok` high and at least one block unlocked, pulses `seq_req` with `seq_op`=1 and `seq_mask` equal to the set of unlocked blocks. The same sequence with `vpp_ok` low issues no request and sets bits 3 and 5.
- R8: 30h followed by D0h when every block is locked, with `vpp_ok` high, issues no request and sets bits 1 and 5.
- R9: 30h followed by any byte other than D0h issues no request and sets bits 4 and 5.
- R10: Error bits 1, 3, 4 and 5 stay set through later commands and operations until 50h is written, which clears all four.
- R11: Writes made while `seq_busy` is 1 are ignored. They change neither the read mode nor the sequence state.
- R12: In idle state a byte other than FFh, 70h, 50h, 40h, 10h or 30h is ignored. It starts no sequence and changes neither the read mode nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; command byte in bits 7:0 |
| arr_rdata | input | DW | Data from the array model |
| rd_data | output | DW | Read port: array data or status word |
| vpp_ok | input | 1 | Programming supply above lockout |
| wp_n | input | 1 | Write-protect, high allows boot-block changes |
| lock_bits | input | NBLK | Per-block lock bits |
| seq_busy | input | 1 | Sequencer busy |
| seq_req | output | 1 | One-cycle operation request |
| seq_op | output | 1 | 0 = word program, 1 = full-chip erase |
| seq_addr | output | AW | Captured program address |
| seq_data | output | DW | Captured program data |
| seq_mask | output | NBLK | Blocks to erase |
| ry_by | output | 1 | Low while the sequencer is busy |

## Verification
Read mode and status error bits update on the clock edge that accepts the write, so they are visible from the next falling edge. `seq_req` rises on that same edge and lasts one cycle. The ready bit and `ry_by` follow `seq_busy` without delay. The bench drives each write on a falling edge and samples on the following falling edge, so every result is read in the cycle it first becomes due. The bench's sequencer model raises busy on the edge after a request, and the busy-time writes are placed after that edge.

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int BLK_BITS  = 3,
  parameter int BOOT_BLKS = 2,
  parameter int NBLK      = 1 << BLK_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   arr_rdata,
  output logic [DW-1:0]   rd_data,
  input  logic            vpp_ok,
  input  logic            wp_n,
  input  logic [NBLK-1:0] lock_bits,
  input  logic            seq_busy,
  output logic            seq_req,
  output logic            seq_op,
  output logic [AW-1:0]   seq_addr,
  output logic [DW-1:0]   seq_data,
  output logic [NBLK-1:0] seq_mask,
  output logic            ry_by
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PROG = 2'd1, ST_CHIP = 2'd2} st_t;

  localparam logic [7:0] C_ARRAY = 8'hFF;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_CLR   = 8'h50;
  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_PROG2 = 8'h10;
  localparam logic [7:0] C_CHIP  = 8'h30;
  localparam logic [7:0] C_CONF  = 8'hD0;

  st_t st;
  logic rd_stat;
  logic e_ers, e_prg, e_vpp, e_lck;
  logic [NBLK-1:0] eff_lock;
  logic [BLK_BITS-1:0] blk;
  logic accept;
  logic [7:0] cmd;
  logic [7:0] stat8;

  for (genvar i = 0; i < NBLK; i++) begin : g_lock
    assign eff_lock[i] = lock_bits[i] | ((i < BOOT_BLKS) & ~wp_n);
  end

  assign blk    = wr_addr[AW-1 -: BLK_BITS];
  assign accept = wr_en & ~seq_busy;
  assign cmd    = wr_data[7:0];
  assign stat8  = {~seq_busy, 1'b0, e_ers, e_prg, e_vpp, 1'b0, e_lck, 1'b0};
  assign rd_data = rd_stat ? {{(DW-8){1'b0}}, stat8} : arr_rdata;
  assign ry_by  = ~seq_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rd_stat  <= 1'b0;
      e_ers    <= 1'b0;
      e_prg    <= 1'b0;
      e_vpp    <= 1'b0;
      e_lck    <= 1'b0;
      seq_req  <= 1'b0;
      seq_op   <= 1'b0;
      seq_addr <= '0;
      seq_data <= '0;
      seq_mask <= '0;
    end else begin
      seq_req <= 1'b0;
      if (accept) begin
        case (st)
          ST_IDLE: begin
            case (cmd)
              C_ARRAY: rd_stat <= 1'b0;
              C_STAT:  rd_stat <= 1'b1;
              C_CLR: begin
                e_ers <= 1'b0;
                e_prg <= 1'b0;
                e_vpp <= 1'b0;
                e_lck <= 1'b0;
              end
              C_PROG, C_PROG2: begin
                st      <= ST_PROG;
                rd_stat <= 1'b1;
              end
              C_CHIP: begin
                st      <= ST_CHIP;
                rd_stat <= 1'b1;
              end
              default: ;
            endcase
          end
          ST_PROG: begin
            st      <= ST_IDLE;
            rd_stat <= 1'b1;
            if (!vpp_ok) begin
              e_vpp <= 1'b1;
              e_prg <= 1'b1;
            end else if (eff_lock[blk]) begin
              e_lck <= 1'b1;
              e_prg <= 1'b1;
            end else begin
              seq_req  <= 1'b1;
              seq_op   <= 1'b0;
              seq_addr <= wr_addr;
              seq_data <= wr_data;
            end
          end
          ST_CHIP: begin
            st      <= ST_IDLE;
            rd_stat <= 1'b1;
            if (cmd != C_CONF) begin
              e_ers <= 1'b1;
              e_prg <= 1'b1;
            end else if (!vpp_ok) begin
              e_vpp <= 1'b1;
              e_ers <= 1'b1;
            end else if (&eff_lock) begin
              e_lck <= 1'b1;
              e_ers <= 1'b1;
            end else begin
              seq_req  <= 1'b1;
              seq_op   <= 1'b1;
              seq_mask <= ~eff_lock;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          seq_busy,
  input logic          vpp_ok,
  input logic          seq_req,
  input logic [1:0]    st,
  input logic [3:0]    errv
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |=> !seq_req); // R2

  AST_NO_REQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(seq_busy) |-> !seq_req); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && !seq_busy && st == 2'd0 && wr_data[7:0] == 8'h50)
      |-> ((errv & $past(errv)) == $past(errv))); // R10

  AST_VPP_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !seq_busy && st == 2'd1 && !vpp_ok)
      |-> (!seq_req && errv[2] && errv[1])); // R5

  AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !seq_busy && st == 2'd2 && wr_data[7:0] != 8'hD0)
      |-> (!seq_req && errv[3] && errv[2])); // R9

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .seq_busy(seq_busy), .vpp_ok(vpp_ok), .seq_req(seq_req),
  .st(st), .errv({e_ers, e_prg, e_vpp, e_lck})
);

// File: tb/flash_cmd_if_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_if_tb_top;
  localparam int AW = 8, DW = 16, BB = 3, NB = 8;
  localparam logic [DW-1:0] ARR = 16'h5A3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic vpp_ok = 1'b1, wp_n = 1'b1;
  logic [NB-1:0] lock_bits = '0;
  logic seq_busy;
  logic seq_req, seq_op, ry_by;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic [NB-1:0] seq_mask;
  logic [3:0] bcnt;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_cmd_if #(.AW(AW), .DW(DW), .BLK_BITS(BB), .BOOT_BLKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_rdata(ARR), .rd_data(rd_data), .vpp_ok(vpp_ok), .wp_n(wp_n),
    .lock_bits(lock_bits), .seq_busy(seq_busy), .seq_req(seq_req), .seq_op(seq_op),
    .seq_addr(seq_addr), .seq_data(seq_data), .seq_mask(seq_mask), .ry_by(ry_by));

  always @(posedge clk) begin
    if (!rst_n) begin
      seq_busy <= 1'b0;
      bcnt <= '0;
    end else if (seq_req) begin
      seq_busy <= 1'b1;
      bcnt <= 4'd4;
    end else if (bcnt != 0) begin
      bcnt <= bcnt - 1'b1;
      if (bcnt == 4'd1) seq_busy <= 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (seq_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == ARR, "R1 array after reset", rd_data, ARR);
    chk(ry_by == 1'b1 && seq_req == 1'b0, "R1 idle outputs", {ry_by, seq_req}, 2'b10);
    wr(0, 16'h0070);
    chk(rd_data == 16'h0080, "R1 clean status", rd_data, 16'h0080);

    // R12: unassigned bytes ignored in idle
    wr(0, 16'h00FF);
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hFF || c == 8'h70 || c == 8'h50 || c == 8'h40 || c == 8'h10 || c == 8'h30) continue;
      wr(0, 16'(c));
      chk(rd_data == ARR && !seq_req, "R12 mode kept", rd_data, ARR);
      wr(0, 16'h0070);
      chk(!seq_req && rd_data == 16'h0080, "R12 no sequence", rd_data, 16'h0080);
      wr(0, 16'h00FF);
    end

    // R2 R5 R6: program sweep
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 2; l++)
          for (int v = 0; v < 2; v++) begin
            logic el, er;
            logic [15:0 ] es;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            string tg;
            lock_bits = l ? NB'(1 << b) : '0;
            wp_n = w[0];
            vpp_ok = v[0];
            el = l[0] || (b < 2 && w == 0);
            er = v[0] && !el;
            es = !v[0] ? 16'h0098 : (el ? 16'h0092 : 16'h0080);
            tg = !v[0] ? "R5" : (el ? "R6" : "R2");
            a = {b[2:0], 5'h0A};
            d = 16'(16'hC300 + b * 8 + w * 4 + l * 2 + v);
            wr(0, 16'h0050);
            wr(0, (b % 2) ? 16'h0010 : 16'h0040);
            chk(rd_data == 16'h0080, "R3 status after setup", rd_data, 16'h0080);
            wr(a, d);
            chk(seq_req == er, {tg, " request"}, seq_req, er);
            chk(rd_data == es, {tg, " status"}, rd_data, es);
            if (er) chk(seq_op == 1'b0 && seq_addr == a && seq_data == d, "R2 captured",
                        {seq_op, seq_addr, seq_data}, {1'b0, a, d});
            @(negedge clk);
            if (er) begin
              chk(seq_req == 1'b0, "R2 single pulse", seq_req, 0);
              chk(ry_by == 1'b0 && rd_data == (es & 16'h007F), "R4 busy", {ry_by, rd_data}, {1'b0, es & 16'h007F});
            end
            wait_idle();
            chk(ry_by == 1'b1 && rd_data == es, "R4 ready", {ry_by, rd_data}, {1'b1, es});
          end

    // R3 read mode switches
    wr(0, 16'h00FF);
    chk(rd_data == ARR, "R3 FF array", rd_data, ARR);
    wr(0, 16'h0070);
    chk(rd_data[15:8] == 8'h00 && rd_data[7] == 1'b1, "R3 70 status", rd_data, 16'h0080);

    // R7 R8: full-chip erase sweep
    for (int lk = 0; lk < 256; lk++)
      for (int w = 0; w < 2; w++)
        for (int v = 0; v < 2; v++) begin
          logic [NB-1:0] el;
          logic er;
          logic [15:0] es;
          lock_bits = NB'(lk);
          wp_n = w[0];
          vpp_ok = v[0];
          el = NB'(lk) | (w == 0 ? NB'(3) : NB'(0));
          er = v[0] && (el != '1);
          es = !v[0] ? 16'h00A8 : (er ? 16'h0080 : 16'h00A2);
          wr(0, 16'h0050);
          wr(0, 16'h0030);
          wr(0, 16'h00D0);
          chk(seq_req == er, !v[0] ? "R7 vpp request" : (er ? "R7 request" : "R8 request"), seq_req, er);
          chk(rd_data == es, !v[0] ? "R7 vpp status" : (er ? "R7 status" : "R8 status"), rd_data, es);
          if (er) chk(seq_op == 1'b1 && seq_mask == ~el, "R7 mask", {seq_op, seq_mask}, {1'b1, ~el});
          wait_idle();
        end
    lock_bits = '0; wp_n = 1'b1; vpp_ok = 1'b1;

    // R9 invalid confirm
    for (int c = 0; c < 256; c++) begin
      if (c == 8'hD0) continue;
      wr(0, 16'h0050);
      wr(0, 16'h0030);
      wr(0, 16'(c));
      chk(!seq_req && rd_data == 16'h00B0, "R9 bad confirm", rd_data, 16'h00B0);
    end

    // R10 sticky errors
    wr(0, 16'h00FF);
    wr(0, 16'h0070);
    chk(rd_data == 16'h00B0, "R10 kept over mode change", rd_data, 16'h00B0);
    wr(0, 16'h0040);
    wr(8'h80, 16'h1111);
    chk(seq_req && rd_data == 16'h00B0, "R10 kept over operation", rd_data, 16'h00B0);
    wait_idle();
    wr(0, 16'h0050);
    chk(rd_data == 16'h0080, "R10 cleared", rd_data, 16'h0080);

    // R11 writes while busy
    wr(0, 16'h0040);
    wr(8'hE0, 16'h2222);
    chk(seq_req == 1'b1, "R11 setup request", seq_req, 1);
    wr(0, 16'h00FF);
    chk(rd_data == 16'h0000, "R11 FF ignored", rd_data, 16'h0000);
    wr(0, 16'h0040);
    wait_idle();
    wr(0, 16'h0070);
    chk(!seq_req && rd_data == 16'h0080, "R11 setup ignored", {seq_req, rd_data}, 17'h00080);

    summary();
    $finish;
  end
endmodule